// File: doc/BRIEF.md
# Range-Reduced Power Gain Unit

This block produces the scaling gain T^(-gamma) that a fractional-order differintegral stage applies to its weighted sum. It never evaluates a general power. It forms the exponent x = -gamma * ln(T) from a gamma value and a logarithm of the sampling interval computed elsewhere, then evaluates exp(x). The exponential core only handles arguments within plus or minus one. The block therefore divides x by ten, evaluates exp(x/10) with a sixth-order Taylor polynomial in Horner form, and restores the full value by raising the result to the tenth power.

One shared fixed-point multiplier does all the work over successive cycles, under a small state machine. The states are `S_IDLE`, `S_SCALE`, `S_HCOEF`, `S_HACC`, `S_SQ2`, `S_SQ4`, `S_SQ8`, `S_MUL10` and `S_FIN`. The transitions are as follows:

- `S_IDLE` to `S_SCALE` on a start with an exponent in range.
- `S_IDLE` to `S_FIN` on a start with an exponent out of range.
- `S_SCALE` to `S_HCOEF`.
- `S_HCOEF` to `S_HACC`.
- `S_HACC` back to `S_HCOEF` while Horner terms remain, and to `S_SQ2` after the last term.
- `S_SQ2` to `S_SQ4` to `S_SQ8` to `S_MUL10` to `S_FIN`.
- `S_FIN` to `S_IDLE`.

A start pulse in idle launches one evaluation. A one-cycle done pulse marks the new gain.

Top module: `rpg_gain_unit`

## Requirements
- R1: `gamma_i` and `ln_t_i` are signed two's-complement 24-bit values with 17 fraction bits. `gain_o` is unsigned 32-bit with 16 fraction bits. For an in-range exponent x = -gamma*ln_t, `gain_o` equals exp(x)*65536 within 1% relative error plus 2 LSB.
- R2: Exponents of exactly +10 and exactly -10 count as in range. They produce exp(10) and exp(-10) within the R1 tolerance, with `out_of_range_o` low.
- R3: For an in-range exponent, `done_o` is high after the 18th rising edge that follows the edge that samples `start_i`. This is 2 + 2*6 + 4 cycles.
- R4: `done_o` is high for exactly one cycle per evaluation.
- R5: `gain_o` and `out_of_range_o` change only on the edge that raises `done_o`. They hold otherwise, even when the inputs change without a start.
- R6: An exponent above +10 sets `out_of_range_o` to 1 and `gain_o` to 0xFFFFFFFF. `done_o` is high one cycle after the sampling edge.
- R7: An exponent below -10 sets `out_of_range_o` to 1 and `gain_o` to 0. `done_o` is high one cycle after the sampling edge.
- R8: A start pulse while an evaluation is in progress is ignored. The running result is unaffected and no extra done pulse follows.
- R9: After reset, `gain_o` is 0, `done_o` is 0 and `out_of_range_o` is 0.
- R10: An in-range evaluation that follows an out-of-range one clears `out_of_range_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one evaluation when the unit is idle |
| gamma_i | input | 24 | Fractional order, signed, 17 fraction bits |
| ln_t_i | input | 24 | Natural log of the sampling interval, signed, 17 fraction bits |
| gain_o | output | 32 | Gain exp(-gamma*ln_t), unsigned, 16 fraction bits |
| done_o | output | 1 | One-cycle pulse when a new gain is present |
| out_of_range_o | output | 1 | Exponent magnitude exceeded ten in the last evaluation |

## Verification
The bench uses the default parameters: 24-bit inputs with 17 fraction bits, a 48-bit internal word with 28 fraction bits, a 16.16 output and a sixth-order series. With these values both exponent limits of plus and minus ten are exactly representable as products of input codes, so the boundary cases and the codes one LSB beyond them can be driven directly. The 16 integer output bits hold exp(10) without clipping, so the largest in-range gain is checked by value rather than by saturation. The fraction bits keep exp(-10) at a few LSB, where the absolute tolerance matters.

// File: rtl/rpg_pkg.sv
`timescale 1ns/1ps
package rpg_pkg;

    // Sequencer states of the gain unit
    typedef enum logic [3:0] {
        S_IDLE,
        S_SCALE,
        S_HCOEF,
        S_HACC,
        S_SQ2,
        S_SQ4,
        S_SQ8,
        S_MUL10,
        S_FIN
    } rpg_state_t;

endpackage

// File: rtl/rpg_exp_arg.sv
`timescale 1ns/1ps
// Forms x = -gamma*ln_t, flags |x| > limit, realigns x to the internal format
module rpg_exp_arg #(
    parameter int IN_W      = 24,
    parameter int IN_FRAC   = 17,
    parameter int W_I       = 48,
    parameter int FRAC_I    = 28,
    parameter int EXP_LIMIT = 10
) (
    input  logic signed [IN_W-1:0] gamma_i,
    input  logic signed [IN_W-1:0] ln_i,
    output logic signed [W_I-1:0]  arg_o,
    output logic                   over_pos_o,
    output logic                   over_neg_o
);
    localparam int PW = 2 * IN_W;
    localparam int PF = 2 * IN_FRAC;
    localparam int SH = PF - FRAC_I;
    localparam logic signed [PW-1:0] LIM = PW'(EXP_LIMIT) <<< PF;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] nprod;

    assign prod  = $signed({{IN_W{gamma_i[IN_W-1]}}, gamma_i}) *
                   $signed({{IN_W{ln_i[IN_W-1]}}, ln_i});
    assign nprod = -prod;

    assign over_pos_o = nprod > LIM;
    assign over_neg_o = nprod < -LIM;

    generate
        if (SH >= 0) begin : g_down
            assign arg_o = W_I'(nprod >>> SH);
        end else begin : g_up
            assign arg_o = W_I'(nprod) <<< (-SH);
        end
    endgenerate

endmodule

// File: rtl/rpg_fx_mul.sv
`timescale 1ns/1ps
// Signed fixed-point product with realignment and saturation
module rpg_fx_mul #(
    parameter int W    = 48,
    parameter int FRAC = 28
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] p_o
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] MAXP = $signed({{(W+1){1'b0}}, {(W-1){1'b1}}});
    localparam logic signed [PW-1:0] MINP = $signed({{(W+1){1'b1}}, {(W-1){1'b0}}});

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;

    assign full    = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    assign shifted = full >>> FRAC;

    always_comb begin
        if (shifted > MAXP) begin
            p_o = MAXP[W-1:0];
        end else if (shifted < MINP) begin
            p_o = MINP[W-1:0];
        end else begin
            p_o = shifted[W-1:0];
        end
    end

endmodule

// File: rtl/rpg_gain_unit.sv
`timescale 1ns/1ps
module rpg_gain_unit
    import rpg_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter int IN_FRAC   = 17,
    parameter int W_I       = 48,
    parameter int FRAC_I    = 28,
    parameter int OUT_W     = 32,
    parameter int OUT_FRAC  = 16,
    parameter int TAYLOR_N  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic signed [IN_W-1:0] gamma_i,
    input  logic signed [IN_W-1:0] ln_t_i,
    output logic [OUT_W-1:0]      gain_o,
    output logic                  done_o,
    output logic                  out_of_range_o
);
    localparam int DIVISOR = 10;
    localparam int KW      = $clog2(TAYLOR_N + 1);
    localparam int OSH     = FRAC_I - OUT_FRAC;
    localparam logic signed [W_I-1:0] ONE = W_I'(64'sd1 <<< FRAC_I);
    localparam logic signed [W_I-1:0] K10 = ONE / W_I'(DIVISOR);
    localparam logic signed [W_I-1:0] OUT_MAX = $signed({{(W_I-OUT_W){1'b0}}, {OUT_W{1'b1}}});

    rpg_state_t state_q, state_d;

    logic signed [W_I-1:0] arg_w, arg_q, a_q, acc_q, t_q, p2_q, pw_q;
    logic signed [W_I-1:0] ma, mb, prod;
    logic signed [W_I-1:0] gsh;
    logic [OUT_W-1:0]      gfmt;
    logic [KW-1:0]         k_q;
    logic                  over_pos, over_neg, hi_q, lo_q;
    logic signed [W_I-1:0] inv_tab [1:TAYLOR_N];

    // Reciprocal constants 1/k for the Horner steps
    generate
        for (genvar g = 1; g <= TAYLOR_N; g++) begin : g_inv
            assign inv_tab[g] = ONE / W_I'(g);
        end
    endgenerate

    rpg_exp_arg #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .W_I(W_I), .FRAC_I(FRAC_I), .EXP_LIMIT(DIVISOR)
    ) u_arg (
        .gamma_i(gamma_i), .ln_i(ln_t_i), .arg_o(arg_w),
        .over_pos_o(over_pos), .over_neg_o(over_neg)
    );

    rpg_fx_mul #(.W(W_I), .FRAC(FRAC_I)) u_mul (.a_i(ma), .b_i(mb), .p_o(prod));

    // Operand selection for the shared multiplier
    always_comb begin
        ma = '0;
        mb = '0;
        unique case (state_q)
            S_SCALE: begin ma = arg_q; mb = K10;          end
            S_HCOEF: begin ma = acc_q; mb = inv_tab[k_q]; end
            S_HACC:  begin ma = a_q;   mb = t_q;          end
            S_SQ2:   begin ma = acc_q; mb = acc_q;        end
            S_SQ4:   begin ma = p2_q;  mb = p2_q;         end
            S_SQ8:   begin ma = pw_q;  mb = pw_q;         end
            S_MUL10: begin ma = pw_q;  mb = p2_q;         end
            default: begin ma = '0;    mb = '0;           end
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = (over_pos || over_neg) ? S_FIN : S_SCALE;
            S_SCALE: state_d = S_HCOEF;
            S_HCOEF: state_d = S_HACC;
            S_HACC:  state_d = (k_q == KW'(1)) ? S_SQ2 : S_HCOEF;
            S_SQ2:   state_d = S_SQ4;
            S_SQ4:   state_d = S_SQ8;
            S_SQ8:   state_d = S_MUL10;
            S_MUL10: state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0;
            a_q   <= '0;
            acc_q <= '0;
            t_q   <= '0;
            p2_q  <= '0;
            pw_q  <= '0;
            k_q   <= '0;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    arg_q <= arg_w;
                    hi_q  <= over_pos;
                    lo_q  <= over_neg;
                end
                S_SCALE: begin
                    a_q   <= prod;
                    acc_q <= ONE;
                    k_q   <= KW'(TAYLOR_N);
                end
                S_HCOEF: t_q <= prod;
                S_HACC: begin
                    acc_q <= ONE + prod;
                    k_q   <= k_q - KW'(1);
                end
                S_SQ2:   p2_q <= prod;
                S_SQ4:   pw_q <= prod;
                S_SQ8:   pw_q <= prod;
                S_MUL10: pw_q <= prod;
                default: ;
            endcase
        end
    end

    // Output format conversion
    assign gsh = pw_q >>> OSH;
    always_comb begin
        if (gsh < 0) begin
            gfmt = '0;
        end else if (gsh > OUT_MAX) begin
            gfmt = '1;
        end else begin
            gfmt = gsh[OUT_W-1:0];
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_o         <= '0;
            done_o         <= 1'b0;
            out_of_range_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == S_FIN) begin
                done_o         <= 1'b1;
                out_of_range_o <= hi_q || lo_q;
                gain_o         <= hi_q ? '1 : (lo_q ? '0 : gfmt);
            end
        end
    end

    // R4: done is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: result held between completions
    a_r5_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(gain_o) && $stable(out_of_range_o));

    // R6: over-range start skips the series
    a_r6_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && (over_pos || over_neg)) |=> state_q == S_FIN);

    // R6/R7: saturated codes only
    a_r7_sat_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && out_of_range_o) |-> (gain_o == '1 || gain_o == '0));

    // R1: an in-range result is strictly positive
    a_r1_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !out_of_range_o) |-> gain_o != '0);

    // R3: Horner index stays within the series order
    a_r3_term_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HACC) |-> (k_q >= KW'(1) && k_q <= KW'(TAYLOR_N)));

endmodule

// File: tb/rpg_gain_unit_bench.sv
`timescale 1ns/1ps
module rpg_gain_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [23:0] gam = '0;
    logic signed [23:0] lnt = '0;
    logic [31:0] gain;
    logic done, oor;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rpg_gain_unit u_rpg_gain_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .gamma_i(gam), .ln_t_i(lnt),
        .gain_o(gain), .done_o(done), .out_of_range_o(oor)
    );

    function automatic int code(input real x);
        return $rtoi(x * 131072.0 + ((x >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Launch one evaluation, return cycles until done
    task automatic launch(input int gc, input int lc, output int lat);
        @(negedge clk);
        gam = 24'(gc); lnt = 24'(lc); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Full check of one evaluation against exp()
    task automatic run_case(input int gc, input int lc, input string req);
        int lat;
        real x, expd, act;
        bit over;
        x = -(real'(gc) / 131072.0) * (real'(lc) / 131072.0);
        over = (x > 10.0) || (x < -10.0);
        launch(gc, lc, lat);
        if (over) begin
            check(lat == 1, (x > 0.0) ? "R6" : "R7",
                  $sformatf("latency act %0d exp 1", lat));
            check(oor == 1'b1, (x > 0.0) ? "R6" : "R7",
                  $sformatf("oor act %0b exp 1", oor));
            check(gain == ((x > 0.0) ? 32'hFFFF_FFFF : 32'h0), (x > 0.0) ? "R6" : "R7",
                  $sformatf("gain act %h exp %h", gain, (x > 0.0) ? 32'hFFFF_FFFF : 32'h0));
        end else begin
            expd = $exp(x) * 65536.0;
            act  = real'(gain);
            check(lat == 18, "R3", $sformatf("latency act %0d exp 18", lat));
            check(oor == 1'b0, req, $sformatf("oor act %0b exp 0", oor));
            check((act - expd <= 0.01 * expd + 2.0) && (expd - act <= 0.01 * expd + 2.0), req,
                  $sformatf("x=%f gain act %0d exp %f", x, gain, expd));
        end
        @(negedge clk);
        check(done == 1'b0, "R4", $sformatf("done after pulse act %0b exp 0", done));
    endtask

    // R9: reset values
    task automatic t_reset();
        check(gain == 32'h0 && done == 1'b0 && oor == 1'b0, "R9",
              $sformatf("reset gain %h done %0b oor %0b exp 0 0 0", gain, done, oor));
    endtask

    // R1: typical exponents
    task automatic t_basic();
        run_case(code(0.0),  code(-7.6009), "R1");
        run_case(code(0.2),  code(-7.6009), "R1");
        run_case(code(-0.6), code(-7.6009), "R1");
        run_case(code(0.99), code(-7.6009), "R1");
        run_case(code(0.5),  code(3.25),    "R1");
    endtask

    // R2/R6/R7: limits and just beyond
    task automatic t_edges();
        run_case(131072, -1310720, "R2");
        run_case(131072,  1310720, "R2");
        run_case(131072, -1310721, "R6");
        run_case(131072,  1310721, "R7");
    endtask

    // R5 and R10: hold behaviour and flag clearing
    task automatic t_hold();
        logic [31:0] g0;
        logic o0;
        run_case(262144, -786432, "R6");
        g0 = gain; o0 = oor;
        gam = 24'(code(0.3)); lnt = 24'(code(-2.0));
        repeat (10) @(negedge clk);
        check(gain == g0 && oor == o0, "R5",
              $sformatf("held gain %h oor %0b exp %h %0b", gain, oor, g0, o0));
        run_case(code(0.3), code(-2.0), "R10");
        check(oor == 1'b0, "R10", $sformatf("oor act %0b exp 0", oor));
    endtask

    // R8: start during evaluation ignored
    task automatic t_busy();
        int lat;
        int extra;
        real expd;
        expd = $exp(-(0.25) * (-4.0)) * 65536.0;
        @(negedge clk);
        gam = 24'(code(0.25)); lnt = 24'(code(-4.0)); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 3) begin
                gam = 24'(code(2.0)); lnt = 24'(code(-7.0)); start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(lat == 18, "R8", $sformatf("latency act %0d exp 18", lat));
        check((real'(gain) - expd <= 0.01 * expd + 2.0) && (expd - real'(gain) <= 0.01 * expd + 2.0)
              && oor == 1'b0, "R8", $sformatf("gain act %0d oor %0b exp %f 0", gain, oor, expd));
        extra = 0;
        repeat (30) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R8", $sformatf("extra done pulses act %0d exp 0", extra));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edges();
        t_hold();
        t_busy();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run act hung exp finished");
        summary();
        $finish;
    end

endmodule